// File: doc/BRIEF.md
# LUT-Mapped Histogram Accumulator

This block builds an image histogram at pixel rate. Each accepted pixel is first passed through one of four host-loaded point-wise lookup tables. The table output names a bin in an accumulation memory, and that bin is incremented by one. A bin saturates instead of wrapping. Three bins are in flight at any time, and a forwarding path keeps back-to-back hits on the same bin exact.

The host loads the tables and reads the bins back through one port. A clear command sweeps the accumulation memory to zero, one word per clock, and raises a busy flag for the whole sweep. While the flag is high, incoming pixels are dropped. For histogram equalization, the host can switch the bin readout to cumulative mode. A running adder then returns the sum of every bin from address zero up to the address being read, provided the host reads in ascending order.

Top module: `lutHistAccum`

## Requirements
- R1: There are four lookup tables. Each holds 2^PIX_W entries of PIX_W bits. When hostWrEn is high and computeEn is low at a clock edge, hostWrData is written into table hostTable at entry hostAddr.
- R2: A pixel is accepted at a clock edge when computeEn and pixValid are high and busy and clearReq are low. Acceptance increments the bin whose address is entry pixIn of table tableSel. A host read issued three or more cycles after the accepting edge returns the new count.
- R3: A bin that holds 2^BIN_W-1 keeps that value when it is incremented again.
- R4: When several pixels map to the same bin on consecutive cycles, every one of them is counted.
- R5: A clearReq seen while busy is low raises busy from the next cycle. busy then stays high for exactly 2^PIX_W+2 cycles, after which every bin reads zero. A clearReq seen while busy is high has no effect.
- R6: A pixel is not counted if pixValid is low, if computeEn is low, if busy is high, or if clearReq is high in the same cycle.
- R7: A hostRdEn at a clock edge makes hostRdValid high in the following cycle, with hostRdData holding the result. With hostRdLut=1 the result is the table entry (table hostTable, entry hostAddr), zero-extended. With hostRdLut=0 the result is bin hostAddr. hostRdValid is low in a cycle that follows no read.
- R8: With cumMode=1 and hostRdLut=0, a read of address 0 returns bin 0 and restarts the running sum. Each later read returns the previous result plus the bin at hostAddr, saturated at 2^BIN_W-1. Reading addresses in ascending order therefore yields the sum of bins 0 through k.
- R9: A table write attempted while computeEn is high leaves the table unchanged.
- R10: After reset, busy and hostRdValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and host clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| computeEn | input | 1 | Compute mode: pixels may count, table writes refused |
| pixValid | input | 1 | Pixel data valid strobe |
| pixIn | input | PIX_W | Incoming pixel value |
| tableSel | input | 2 | Lookup table applied to pixIn |
| clearReq | input | 1 | Start a clear sweep of the bins |
| busy | output | 1 | Clear in progress; pixels dropped |
| hostWrEn | input | 1 | Table write strobe |
| hostTable | input | 2 | Table index for host write and table readback |
| hostAddr | input | PIX_W | Table entry or bin address for host access |
| hostWrData | input | PIX_W | Table write data |
| hostRdEn | input | 1 | Host read strobe |
| hostRdLut | input | 1 | Read target: 1 table entry, 0 bin |
| cumMode | input | 1 | Bin readout as running cumulative sum |
| hostRdData | output | BIN_W | Read result |
| hostRdValid | output | 1 | hostRdData valid |

## Verification
The hardest situation to reach is an increment whose memory read happens at the very edge at which the previous increment of the same bin is written. Only the forwarding path can get that case right. The bench reaches it with tables that fold many pixel values onto one bin: one table maps pairs of adjacent values to a shared bin, and another maps every value to a single constant bin. Sweeping all pixel values through these tables on consecutive cycles produces long runs of same-bin hits, and the counts are read back both before and after that bin saturates. Dropped pixels around a clear are provoked by holding pixValid high from the clearReq cycle until busy falls. Any pixel that slipped through in the last busy cycle would then land in a bin after the sweep had finished.

// File: rtl/lhaPkg.sv
package lhaPkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_DRAIN = 2'd1,
    CS_SWEEP = 2'd2
  } clrState_t;

  typedef struct packed {
    logic pixAccept;
    logic clrWrite;
    logic lutWrite;
  } ctrlStrobe_t;

endpackage

// File: rtl/histCtrl.sv
module histCtrl
  import lhaPkg::*;
#(
  parameter int PIX_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             computeEn,
  input  logic             pixValid,
  input  logic             clearReq,
  input  logic             hostWrEn,
  output ctrlStrobe_t      strb,
  output logic [PIX_W-1:0] clrAddr,
  output logic             busy
);

  localparam int DEPTH = 1 << PIX_W;
  localparam logic [PIX_W-1:0] LAST_ADDR = PIX_W'(DEPTH - 1);

  clrState_t state;
  logic      drainCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= CS_IDLE;
      drainCnt <= 1'b0;
      clrAddr  <= '0;
    end else begin
      unique case (state)
        CS_IDLE: begin
          if (clearReq) begin
            state    <= CS_DRAIN;
            drainCnt <= 1'b0;
          end
        end
        CS_DRAIN: begin
          if (drainCnt) begin
            state   <= CS_SWEEP;
            clrAddr <= '0;
          end else begin
            drainCnt <= 1'b1;
          end
        end
        CS_SWEEP: begin
          if (clrAddr == LAST_ADDR) state <= CS_IDLE;
          else                      clrAddr <= clrAddr + 1'b1;
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign busy = (state != CS_IDLE);

  always_comb begin
    strb.pixAccept = computeEn && pixValid && !busy && !clearReq;
    strb.clrWrite  = (state == CS_SWEEP);
    strb.lutWrite  = hostWrEn && !computeEn;
  end

  // checker: busy window length measured independently
  logic [PIX_W+1:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  a_r5_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !busy) |=> busy);

  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == (PIX_W+2)'(DEPTH + 2)));

endmodule

// File: rtl/lutBank.sv
module lutBank #(
  parameter int PIX_W  = 9,
  parameter int TABLES = 4
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [$clog2(TABLES)-1:0] wrTable,
  input  logic [PIX_W-1:0]          wrAddr,
  input  logic [PIX_W-1:0]          wrData,
  input  logic [$clog2(TABLES)-1:0] pipeTable,
  input  logic [PIX_W-1:0]          pipeAddr,
  input  logic [$clog2(TABLES)-1:0] hostTable,
  input  logic [PIX_W-1:0]          hostAddr,
  output logic [PIX_W-1:0]          pipeQ,
  output logic [PIX_W-1:0]          hostQ
);

  localparam int DEPTH = 1 << PIX_W;
  localparam int TSEL_W = $clog2(TABLES);

  logic [TABLES-1:0][PIX_W-1:0] pipeArr;
  logic [TABLES-1:0][PIX_W-1:0] hostArr;
  logic [TSEL_W-1:0]            pipeSelQ;
  logic [TSEL_W-1:0]            hostSelQ;

  for (genvar t = 0; t < TABLES; t++) begin : gTable
    logic [PIX_W-1:0] mem [DEPTH];
    logic [PIX_W-1:0] pq;
    logic [PIX_W-1:0] hq;

    always_ff @(posedge clk) begin
      if (we && (wrTable == TSEL_W'(t))) mem[wrAddr] <= wrData;
      pq <= mem[pipeAddr];
      hq <= mem[hostAddr];
    end

    assign pipeArr[t] = pq;
    assign hostArr[t] = hq;
  end

  always_ff @(posedge clk) begin
    pipeSelQ <= pipeTable;
    hostSelQ <= hostTable;
  end

  assign pipeQ = pipeArr[pipeSelQ];
  assign hostQ = hostArr[hostSelQ];

endmodule

// File: rtl/histDatapath.sv
module histDatapath
  import lhaPkg::*;
#(
  parameter int PIX_W = 9,
  parameter int BIN_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [PIX_W-1:0] clrAddr,
  input  logic [PIX_W-1:0] lutPipeQ,
  input  logic [PIX_W-1:0] lutHostQ,
  input  logic             hostRdEn,
  input  logic             hostRdLut,
  input  logic             cumMode,
  input  logic [PIX_W-1:0] hostAddr,
  output logic [BIN_W-1:0] hostRdData,
  output logic             hostRdValid
);

  localparam int DEPTH = 1 << PIX_W;
  localparam logic [BIN_W-1:0] BIN_MAX = {BIN_W{1'b1}};

  logic [BIN_W-1:0] accMem [DEPTH];

  // increment pipeline: stage1 = table lookup, stage2 = bin read, write
  logic             valid1;
  logic             valid2;
  logic [PIX_W-1:0] addr2;
  logic [BIN_W-1:0] rd2;
  logic             lastValid;
  logic [PIX_W-1:0] lastAddr;
  logic [BIN_W-1:0] lastVal;
  logic [BIN_W-1:0] oldVal;
  logic [BIN_W-1:0] wrVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid1    <= 1'b0;
      valid2    <= 1'b0;
      lastValid <= 1'b0;
    end else begin
      valid1    <= strb.pixAccept;
      valid2    <= valid1;
      lastValid <= valid2;
    end
  end

  always_ff @(posedge clk) begin
    addr2    <= lutPipeQ;
    rd2      <= accMem[lutPipeQ];
    lastAddr <= addr2;
    lastVal  <= wrVal;
  end

  always_comb begin
    oldVal = (lastValid && (lastAddr == addr2)) ? lastVal : rd2;
    wrVal  = (oldVal == BIN_MAX) ? BIN_MAX : oldVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (valid2)             accMem[addr2]   <= wrVal;
    else if (strb.clrWrite) accMem[clrAddr] <= '0;
  end

  // host readout with running cumulative adder
  logic [BIN_W-1:0] hostBin;
  logic [BIN_W-1:0] cumBase;
  logic [BIN_W:0]   cumWide;
  logic [BIN_W-1:0] cumSum;
  logic [BIN_W-1:0] runSum;
  logic [BIN_W-1:0] binQ;
  logic             rdLutQ;

  always_comb begin
    hostBin = accMem[hostAddr];
    cumBase = (hostAddr == '0) ? '0 : runSum;
    cumWide = {1'b0, cumBase} + {1'b0, hostBin};
    cumSum  = cumWide[BIN_W] ? BIN_MAX : cumWide[BIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdValid <= 1'b0;
      runSum      <= '0;
      rdLutQ      <= 1'b0;
      binQ        <= '0;
    end else begin
      hostRdValid <= hostRdEn;
      if (hostRdEn) begin
        rdLutQ <= hostRdLut;
        binQ   <= cumMode ? cumSum : hostBin;
        if (cumMode && !hostRdLut) runSum <= cumSum;
      end
    end
  end

  assign hostRdData = rdLutQ ? {{(BIN_W-PIX_W){1'b0}}, lutHostQ} : binQ;

  a_r6_no_write_clash: assert property (@(posedge clk) disable iff (!rstN)
    !(valid2 && strb.clrWrite));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    valid2 |-> (wrVal != '0));

endmodule

// File: rtl/lutHistAccum.sv
module lutHistAccum
  import lhaPkg::*;
#(
  parameter int PIX_W  = 9,
  parameter int BIN_W  = 24,
  parameter int TABLES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      computeEn,
  input  logic                      pixValid,
  input  logic [PIX_W-1:0]          pixIn,
  input  logic [$clog2(TABLES)-1:0] tableSel,
  input  logic                      clearReq,
  output logic                      busy,
  input  logic                      hostWrEn,
  input  logic [$clog2(TABLES)-1:0] hostTable,
  input  logic [PIX_W-1:0]          hostAddr,
  input  logic [PIX_W-1:0]          hostWrData,
  input  logic                      hostRdEn,
  input  logic                      hostRdLut,
  input  logic                      cumMode,
  output logic [BIN_W-1:0]          hostRdData,
  output logic                      hostRdValid
);

  ctrlStrobe_t      strb;
  logic [PIX_W-1:0] clrAddr;
  logic [PIX_W-1:0] lutPipeQ;
  logic [PIX_W-1:0] lutHostQ;

  histCtrl #(.PIX_W(PIX_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .computeEn (computeEn),
    .pixValid  (pixValid),
    .clearReq  (clearReq),
    .hostWrEn  (hostWrEn),
    .strb      (strb),
    .clrAddr   (clrAddr),
    .busy      (busy)
  );

  lutBank #(.PIX_W(PIX_W), .TABLES(TABLES)) uLut (
    .clk       (clk),
    .we        (strb.lutWrite),
    .wrTable   (hostTable),
    .wrAddr    (hostAddr),
    .wrData    (hostWrData),
    .pipeTable (tableSel),
    .pipeAddr  (pixIn),
    .hostTable (hostTable),
    .hostAddr  (hostAddr),
    .pipeQ     (lutPipeQ),
    .hostQ     (lutHostQ)
  );

  histDatapath #(.PIX_W(PIX_W), .BIN_W(BIN_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .clrAddr     (clrAddr),
    .lutPipeQ    (lutPipeQ),
    .lutHostQ    (lutHostQ),
    .hostRdEn    (hostRdEn),
    .hostRdLut   (hostRdLut),
    .cumMode     (cumMode),
    .hostAddr    (hostAddr),
    .hostRdData  (hostRdData),
    .hostRdValid (hostRdValid)
  );

endmodule

// File: tb/lutHistAccum_test.sv
`timescale 1ns/1ps
module lutHistAccum_test;

  localparam int PW = 4;
  localparam int BW = 6;
  localparam int NT = 4;
  localparam int DEPTH = 1 << PW;
  localparam int BMAX = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          computeEn = 1'b0;
  logic          pixValid = 1'b0;
  logic [PW-1:0] pixIn = '0;
  logic [1:0]    tableSel = '0;
  logic          clearReq = 1'b0;
  logic          busy;
  logic          hostWrEn = 1'b0;
  logic [1:0]    hostTable = '0;
  logic [PW-1:0] hostAddr = '0;
  logic [PW-1:0] hostWrData = '0;
  logic          hostRdEn = 1'b0;
  logic          hostRdLut = 1'b0;
  logic          cumMode = 1'b0;
  logic [BW-1:0] hostRdData;
  logic          hostRdValid;

  int total = 0;
  int bad = 0;
  int lutM [NT][DEPTH];
  int binM [DEPTH];

  always #4 clk = ~clk;

  lutHistAccum #(.PIX_W(PW), .BIN_W(BW), .TABLES(NT)) uut (
    .clk(clk), .rstN(rstN), .computeEn(computeEn), .pixValid(pixValid),
    .pixIn(pixIn), .tableSel(tableSel), .clearReq(clearReq), .busy(busy),
    .hostWrEn(hostWrEn), .hostTable(hostTable), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdLut(hostRdLut),
    .cumMode(cumMode), .hostRdData(hostRdData), .hostRdValid(hostRdValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lutWrite(input int t, input int a, input int d);
    hostWrEn = 1'b1; hostTable = 2'(t); hostAddr = PW'(a); hostWrData = PW'(d);
    tick();
    hostWrEn = 1'b0;
    if (!computeEn) lutM[t][a] = d;
  endtask

  task automatic hostRead(input bit lut, input int t, input int a, output int d);
    hostRdEn = 1'b1; hostRdLut = lut; hostTable = 2'(t); hostAddr = PW'(a);
    tick();
    chk("R7 valid", int'(hostRdValid), 1);
    d = int'(hostRdData);
    hostRdEn = 1'b0;
  endtask

  task automatic sendPix(input int t, input int p);
    pixValid = 1'b1; tableSel = 2'(t); pixIn = PW'(p);
    tick();
    if (computeEn) begin
      int b = lutM[t][p];
      binM[b] = (binM[b] >= BMAX) ? BMAX : binM[b] + 1;
    end
  endtask

  task automatic idle(input int n);
    pixValid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic runClear(input bit holdPix);
    int cnt = 0;
    clearReq = 1'b1;
    if (holdPix) begin
      computeEn = 1'b1; pixValid = 1'b1; tableSel = 2'd0; pixIn = PW'(3);
    end
    tick();
    clearReq = 1'b0;
    while (busy && cnt < 1000) begin
      cnt++;
      tick();
    end
    pixValid = 1'b0;
    computeEn = 1'b0;
    chk("R5 busy length", cnt, DEPTH + 2);
    for (int b = 0; b < DEPTH; b++) binM[b] = 0;
  endtask

  task automatic checkBins(input string req);
    int d;
    for (int b = 0; b < DEPTH; b++) begin
      hostRead(1'b0, 0, b, d);
      chk(req, d, binM[b]);
    end
  endtask

  task automatic checkCum();
    int d, s;
    cumMode = 1'b1;
    s = 0;
    for (int b = 0; b < DEPTH; b++) begin
      s = s + binM[b];
      if (s > BMAX) s = BMAX;
      hostRead(1'b0, 0, b, d);
      chk("R8 cumulative", d, s);
    end
    hostRead(1'b0, 0, 0, d);
    chk("R8 restart at 0", d, binM[0]);
    hostRead(1'b0, 0, 1, d);
    s = binM[0] + binM[1];
    chk("R8 after restart", d, (s > BMAX) ? BMAX : s);
    cumMode = 1'b0;
  endtask

  task automatic sweepAll();
    computeEn = 1'b1;
    for (int t = 0; t < NT; t++)
      for (int p = 0; p < DEPTH; p++) sendPix(t, p);
    pixValid = 1'b0;
    computeEn = 1'b0;
    idle(4);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R10 busy after reset", int'(busy), 0);
    chk("R10 rdvalid after reset", int'(hostRdValid), 0);

    // R1: load all tables: identity, reversed, folded pairs, constant bin 5
    for (int a = 0; a < DEPTH; a++) begin
      lutWrite(0, a, a);
      lutWrite(1, a, DEPTH - 1 - a);
      lutWrite(2, a, a >> 1);
      lutWrite(3, a, 5);
    end
    for (int t = 0; t < NT; t++)
      for (int a = 0; a < DEPTH; a++) begin
        hostRead(1'b1, t, a, d);
        chk("R1 table readback", d, lutM[t][a]);
      end

    // R5: clear then all bins zero
    runClear(1'b0);
    checkBins("R5 bins zero after clear");

    // R2/R4: one pass, folded and constant tables give same-bin runs
    sweepAll();
    checkBins("R2 R4 counts after one pass");
    checkCum();

    // R3: more passes drive bin 5 past saturation
    for (int k = 0; k < 4; k++) sweepAll();
    checkBins("R3 saturated counts");
    checkCum();

    // R6: pixels during busy and on the clearReq cycle are dropped
    runClear(1'b1);
    idle(4);
    checkBins("R6 busy pixels dropped");

    // R5: clearReq while busy has no effect on the sweep length
    clearReq = 1'b1;
    tick();
    begin
      int cnt = 1;
      while (busy && cnt < 1000) begin
        if (cnt == 5) clearReq = 1'b1; else clearReq = 1'b0;
        cnt++;
        tick();
      end
      clearReq = 1'b0;
      chk("R5 clearReq during busy ignored", cnt - 1, DEPTH + 2);
    end

    // R6: pixValid low, and computeEn low
    computeEn = 1'b1;
    for (int p = 0; p < DEPTH; p++) begin
      pixValid = 1'b0; tableSel = 2'd0; pixIn = PW'(p);
      tick();
    end
    computeEn = 1'b0;
    for (int p = 0; p < DEPTH; p++) sendPix(0, p);
    idle(4);
    checkBins("R6 gated pixels dropped");

    // R9: write while computing refused; R1 write when idle accepted
    computeEn = 1'b1;
    lutWrite(1, 2, 7);
    computeEn = 1'b0;
    hostRead(1'b1, 1, 2, d);
    chk("R9 write refused in compute", d, DEPTH - 1 - 2);
    lutWrite(1, 2, 7);
    hostRead(1'b1, 1, 2, d);
    chk("R1 write accepted when idle", d, 7);

    // R2: modified table steers pixel 2 to bin 7
    computeEn = 1'b1;
    sendPix(1, 2);
    sendPix(1, 2);
    sendPix(0, 7);
    computeEn = 1'b0;
    idle(4);
    checkBins("R2 remapped bin");

    tick();
    chk("R7 valid low without read", int'(hostRdValid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule